// File: doc/BRIEF.md
# Dual-Symbol Link Scrambler and Descrambler

This block whitens the byte stream of a serial link. It works on two symbols in each clock cycle, and it has one independent path for each direction. Each path takes a 16-bit word and a per-byte control flag (K flag). Data symbols are XORed with a byte from a 16-bit Galois LFSR. The polynomial is x^16 + x^5 + x^4 + x^3 + 1. The low byte lane is the earlier symbol of the word and the high byte lane is the later one.

Control symbols are never altered. The comma symbol brings the LFSR back to its start state, and the skip symbol freezes it. Both are handled per lane, so a comma or a skip in the low lane already affects the high lane of the same word. Because XOR with the same mask is its own inverse, the transmit path and the receive path share one implementation. A shared bypass input turns whitening off in both paths. A per-direction compliance input stops whitening and freezes the LFSR while a compliance pattern is being sent.

The block sits between the link-layer framing and the 8b/10b coder. Results appear one clock after an input word that is flagged valid.

Top module: `lfsr_scram16`

## Requirements
- R1: A word presented with its valid input high appears on the outputs at the next rising clock edge, with out_valid high. With valid low, out_valid goes low at the next edge.
- R2: A symbol whose K flag is 1 is output unchanged, and its K flag is copied to the output.
- R3: The LFSR step is: shift left by one and, if the old bit 15 was 1, XOR with 16'h0039. The mask for a symbol is built from the state S it meets: mask bit i is bit 15 of S after i steps, for i = 0 to 7. A data symbol (K flag 0) is output as data XOR mask. The state then moves forward 8 steps.
- R4: A comma (K flag 1, value 8'hBC) loads the LFSR with the start state. The start state is 16'hFFFF advanced 8 steps. The next data symbol is masked with the start state.
- R5: A skip (K flag 1, value 8'h1C) leaves the LFSR unchanged. Every other control symbol advances the LFSR 8 steps.
- R6: The rules of R3 to R5 apply lane by lane inside a word. The high lane sees the state left by the low lane of the same word, so a comma in the low lane makes the high lane use the start state.
- R7: While bypass is high, both paths output their data unchanged, and the LFSR still follows R3 to R5.
- R8: While a path's compliance input is high, its data symbols are output unchanged. Its LFSR holds, except that a comma still loads the start state.
- R9: Feeding the transmit output into the receive path returns the original symbols and K flags exactly, when the stream begins with a comma.
- R10: After reset, the outputs and out_valid are 0, and the LFSR holds the start state.
- R11: While valid is low, the path's LFSR and its data and K outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bypass | input | 1 | Disables whitening in both paths |
| tx_compliance | input | 1 | Transmit path is sending a compliance pattern |
| tx_in_valid | input | 1 | Transmit input word valid |
| tx_in_data | input | 16 | Transmit symbols; bits 7:0 are the earlier symbol |
| tx_in_k | input | 2 | Transmit K flags, one per byte lane |
| tx_out_valid | output | 1 | Transmit output word valid |
| tx_out_data | output | 16 | Scrambled transmit symbols |
| tx_out_k | output | 2 | Transmit K flags, delayed |
| rx_compliance | input | 1 | Receive path is carrying a compliance pattern |
| rx_in_valid | input | 1 | Receive input word valid |
| rx_in_data | input | 16 | Received scrambled symbols; bits 7:0 are the earlier symbol |
| rx_in_k | input | 2 | Receive K flags, one per byte lane |
| rx_out_valid | output | 1 | Receive output word valid |
| rx_out_data | output | 16 | Descrambled receive symbols |
| rx_out_k | output | 2 | Receive K flags, delayed |

## Verification
Some properties are checked on every cycle in both paths:
- the one-cycle valid latency;
- unchanged control bytes and copied K flags;
- transparent data under bypass or compliance;
- outputs that hold while valid is low.

The values of the mask cannot be seen by a local property, so the bench's reference model checks them. That covers:
- the mask sequence itself;
- the comma reload and the skip freeze, in either lane of a word;
- the state left after reset;
- the LFSR still stepping under bypass.

A loop-back scenario shows that descrambling inverts scrambling.

// File: rtl/lfsr_scram16_pkg.sv
package lfsr_scram16_pkg;
  localparam int SYM_W  = 8;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h0039;
  localparam logic [SYM_W-1:0]  SYM_COMMA = 8'hBC;
  localparam logic [SYM_W-1:0]  SYM_SKIP  = 8'h1C;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], 1'b0} ^ (s[LFSR_W-1] ? LFSR_TAPS : '0);
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < SYM_W; i++) t = lfsr_step(t);
    return t;
  endfunction

  function automatic logic [SYM_W-1:0] lfsr_mask(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    logic [SYM_W-1:0]  m;
    t = s;
    for (int i = 0; i < SYM_W; i++) begin
      m[i] = t[LFSR_W-1];
      t    = lfsr_step(t);
    end
    return m;
  endfunction

  localparam logic [LFSR_W-1:0] LFSR_START = lfsr_adv(LFSR_SEED);
endpackage

// File: rtl/lfsr_scram16_rst_sync.sv
module lfsr_scram16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lfsr_scram16_lane.sv
module lfsr_scram16_lane
  import lfsr_scram16_pkg::*;
(
  input  logic [LFSR_W-1:0] state_in,
  input  logic [SYM_W-1:0]  sym_in,
  input  logic              k_in,
  input  logic              bypass,
  input  logic              compliance,
  output logic [SYM_W-1:0]  sym_out,
  output logic [LFSR_W-1:0] state_out
);
  logic is_comma;
  logic is_skip;

  always_comb begin
    is_comma  = k_in && (sym_in == SYM_COMMA);
    is_skip   = k_in && (sym_in == SYM_SKIP);
    sym_out   = sym_in;
    state_out = state_in;
    if (is_comma) begin
      state_out = LFSR_START;
    end else if (!is_skip) begin
      if (!k_in && !bypass && !compliance) sym_out = sym_in ^ lfsr_mask(state_in);
      if (!compliance) state_out = lfsr_adv(state_in);
    end
  end
endmodule

// File: rtl/lfsr_scram16_path.sv
module lfsr_scram16_path
  import lfsr_scram16_pkg::*;
#(
  parameter int LANES = 2,
  localparam int DW = LANES * SYM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass,
  input  logic          compliance,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [LANES-1:0] in_k,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [LANES-1:0] out_k
);
  logic [LFSR_W-1:0] state_q, state_d;
  logic [LANES:0][LFSR_W-1:0] st_chain;
  logic [DW-1:0] lane_data;
  logic [DW-1:0] data_d;
  logic [LANES-1:0] k_d;

  assign st_chain[0] = state_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lfsr_scram16_lane u_lane (
      .state_in   (st_chain[g]),
      .sym_in     (in_data[g*SYM_W +: SYM_W]),
      .k_in       (in_k[g]),
      .bypass     (bypass),
      .compliance (compliance),
      .sym_out    (lane_data[g*SYM_W +: SYM_W]),
      .state_out  (st_chain[g+1])
    );
  end

  always_comb begin
    state_d = state_q;
    data_d  = out_data;
    k_d     = out_k;
    if (in_valid) begin
      state_d = st_chain[LANES];
      data_d  = lane_data;
      k_d     = in_k;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LFSR_START;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_k     <= '0;
    end else begin
      state_q   <= state_d;
      out_valid <= in_valid;
      out_data  <= data_d;
      out_k     <= k_d;
    end
  end
endmodule

// File: rtl/lfsr_scram16.sv
module lfsr_scram16
  import lfsr_scram16_pkg::*;
#(
  parameter int LANES = 2,
  localparam int DW = LANES * SYM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic             tx_compliance,
  input  logic             tx_in_valid,
  input  logic [DW-1:0]    tx_in_data,
  input  logic [LANES-1:0] tx_in_k,
  output logic             tx_out_valid,
  output logic [DW-1:0]    tx_out_data,
  output logic [LANES-1:0] tx_out_k,
  input  logic             rx_compliance,
  input  logic             rx_in_valid,
  input  logic [DW-1:0]    rx_in_data,
  input  logic [LANES-1:0] rx_in_k,
  output logic             rx_out_valid,
  output logic [DW-1:0]    rx_out_data,
  output logic [LANES-1:0] rx_out_k
);
  logic rst_sync_n;

  lfsr_scram16_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lfsr_scram16_path #(.LANES(LANES)) u_tx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bypass     (bypass),
    .compliance (tx_compliance),
    .in_valid   (tx_in_valid),
    .in_data    (tx_in_data),
    .in_k       (tx_in_k),
    .out_valid  (tx_out_valid),
    .out_data   (tx_out_data),
    .out_k      (tx_out_k)
  );

  lfsr_scram16_path #(.LANES(LANES)) u_rx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bypass     (bypass),
    .compliance (rx_compliance),
    .in_valid   (rx_in_valid),
    .in_data    (rx_in_data),
    .in_k       (rx_in_k),
    .out_valid  (rx_out_valid),
    .out_data   (rx_out_data),
    .out_k      (rx_out_k)
  );
endmodule

// File: rtl/lfsr_scram16_chk.sv
module lfsr_scram16_chk #(
  parameter int LANES = 2,
  localparam int DW = LANES * 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bypass,
  input logic             compliance,
  input logic             in_valid,
  input logic [DW-1:0]    in_data,
  input logic [LANES-1:0] in_k,
  input logic             out_valid,
  input logic [DW-1:0]    out_data,
  input logic [LANES-1:0] out_k
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid))); // R1

  AST_KFLAG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid)) |-> (out_k == $past(in_k))); // R2

  for (genvar g = 0; g < LANES; g++) begin : g_kchk
    AST_CTRL_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(in_valid) && $past(in_k[g]))
        |-> (out_data[g*8 +: 8] == $past(in_data[g*8 +: 8]))); // R2
  end

  AST_BYPASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid) && $past(bypass)) |-> (out_data == $past(in_data))); // R7

  AST_COMPLIANCE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid) && $past(compliance)) |-> (out_data == $past(in_data))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(in_valid)) |-> ($stable(out_data) && $stable(out_k))); // R11
endmodule

bind lfsr_scram16 lfsr_scram16_chk #(.LANES(LANES)) u_chk_tx (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bypass     (bypass),
  .compliance (tx_compliance),
  .in_valid   (tx_in_valid),
  .in_data    (tx_in_data),
  .in_k       (tx_in_k),
  .out_valid  (tx_out_valid),
  .out_data   (tx_out_data),
  .out_k      (tx_out_k)
);

bind lfsr_scram16 lfsr_scram16_chk #(.LANES(LANES)) u_chk_rx (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bypass     (bypass),
  .compliance (rx_compliance),
  .in_valid   (rx_in_valid),
  .in_data    (rx_in_data),
  .in_k       (rx_in_k),
  .out_valid  (rx_out_valid),
  .out_data   (rx_out_data),
  .out_k      (rx_out_k)
);

// File: tb/lfsr_scram16_test.sv
`timescale 1ns/1ps
module lfsr_scram16_test;
  logic clk;
  logic rst_n;
  logic bypass;
  logic tx_compliance, tx_in_valid, tx_out_valid;
  logic [15:0] tx_in_data, tx_out_data;
  logic [1:0]  tx_in_k, tx_out_k;
  logic rx_compliance, rx_in_valid, rx_out_valid;
  logic [15:0] rx_in_data, rx_out_data;
  logic [1:0]  rx_in_k, rx_out_k;

  int checks;
  int failures;
  bit done;

  logic [15:0] m_tx, m_rx;
  logic        e_tx_v, e_rx_v;
  logic [15:0] e_tx_d, e_rx_d;
  logic [1:0]  e_tx_k, e_rx_k;
  string       pend_tag;

  localparam int RT_N = 64;
  logic [15:0] rt_d  [RT_N];
  logic [1:0]  rt_k  [RT_N];
  logic [15:0] rt_sd [RT_N];
  logic [1:0]  rt_sk [RT_N];

  lfsr_scram16 uut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass),
    .tx_compliance(tx_compliance), .tx_in_valid(tx_in_valid),
    .tx_in_data(tx_in_data), .tx_in_k(tx_in_k),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_k(tx_out_k),
    .rx_compliance(rx_compliance), .rx_in_valid(rx_in_valid),
    .rx_in_data(rx_in_data), .rx_in_k(rx_in_k),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_k(rx_out_k)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] b_step(input logic [15:0] s);
    logic [15:0] n;
    n = s << 1;
    if (s[15]) n = n ^ 16'h0039;
    return n;
  endfunction

  function automatic logic [15:0] b_adv(input logic [15:0] s);
    logic [15:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = b_step(t);
    return t;
  endfunction

  function automatic logic [7:0] b_mask(input logic [15:0] s);
    logic [15:0] t;
    logic [7:0]  m;
    t = s;
    for (int i = 0; i < 8; i++) begin
      m[i] = t[15];
      t = b_step(t);
    end
    return m;
  endfunction

  task automatic model_word(inout logic [15:0] st, input logic [15:0] d,
                            input logic [1:0] k, input logic byp, input logic comp,
                            output logic [15:0] o);
    for (int l = 0; l < 2; l++) begin
      logic [7:0] s;
      s = d[l*8 +: 8];
      o[l*8 +: 8] = s;
      if (k[l] && s == 8'hBC) st = b_adv(16'hFFFF);
      else if (k[l] && s == 8'h1C) st = st;
      else begin
        if (!k[l] && !byp && !comp) o[l*8 +: 8] = s ^ b_mask(st);
        if (!comp) st = b_adv(st);
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string tag, input logic byp,
                       input logic tv, input logic [15:0] td, input logic [1:0] tk, input logic tc,
                       input logic rv, input logic [15:0] rd, input logic [1:0] rk, input logic rc);
    @(negedge clk);
    chk(pend_tag, "tx_valid", {15'd0, tx_out_valid}, {15'd0, e_tx_v});
    chk(pend_tag, "tx_data",  tx_out_data, e_tx_d);
    chk(pend_tag, "tx_k",     {14'd0, tx_out_k}, {14'd0, e_tx_k});
    chk(pend_tag, "rx_valid", {15'd0, rx_out_valid}, {15'd0, e_rx_v});
    chk(pend_tag, "rx_data",  rx_out_data, e_rx_d);
    chk(pend_tag, "rx_k",     {14'd0, rx_out_k}, {14'd0, e_rx_k});
    bypass = byp;
    tx_in_valid = tv; tx_in_data = td; tx_in_k = tk; tx_compliance = tc;
    rx_in_valid = rv; rx_in_data = rd; rx_in_k = rk; rx_compliance = rc;
    e_tx_v = tv;
    if (tv) begin model_word(m_tx, td, tk, byp, tc, e_tx_d); e_tx_k = tk; end
    e_rx_v = rv;
    if (rv) begin model_word(m_rx, rd, rk, byp, rc, e_rx_d); e_rx_k = rk; end
    pend_tag = tag;
  endtask

  task automatic rand_sym(output logic [7:0] d, output logic k);
    int r;
    r = $urandom % 10;
    case (r)
      0: begin d = 8'hBC; k = 1'b1; end
      1: begin d = 8'h1C; k = 1'b1; end
      2: begin d = 8'hF7; k = 1'b1; end
      default: begin d = 8'($urandom); k = 1'b0; end
    endcase
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d0, d1;
    logic [1:0]  k0, k1;
    logic [7:0]  s;
    logic        kk;
    checks = 0; failures = 0; done = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bypass = 1'b0;
    tx_compliance = 0; tx_in_valid = 0; tx_in_data = '0; tx_in_k = '0;
    rx_compliance = 0; rx_in_valid = 0; rx_in_data = '0; rx_in_k = '0;
    m_tx = b_adv(16'hFFFF); m_rx = b_adv(16'hFFFF);
    e_tx_v = 0; e_tx_d = '0; e_tx_k = '0;
    e_rx_v = 0; e_rx_d = '0; e_rx_k = '0;
    pend_tag = "R10";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset values, then R3 first data word uses the start state
    cycle("R10", 0, 1, 16'h0000, 2'b00, 0, 1, 16'h5AA5, 2'b00, 0);
    cycle("R3",  0, 1, 16'h1234, 2'b00, 0, 0, 16'h0, 2'b00, 0);
    // R4 comma in high lane, next word uses start state
    cycle("R4",  0, 1, 16'hBC77, 2'b10, 0, 0, 16'h0, 2'b00, 0);
    cycle("R4",  0, 1, 16'h0000, 2'b00, 0, 0, 16'h0, 2'b00, 0);
    // R6 comma in low lane, data in high lane of the same word
    cycle("R6",  0, 1, 16'h00BC, 2'b01, 0, 1, 16'hA5BC, 2'b01, 0);
    // R5 skip in low lane holds the LFSR for the high lane
    cycle("R5",  0, 1, 16'h001C, 2'b01, 0, 0, 16'h0, 2'b00, 0);
    cycle("R5",  0, 1, 16'h1C1C, 2'b11, 0, 0, 16'h0, 2'b00, 0);
    cycle("R5",  0, 1, 16'h0000, 2'b00, 0, 0, 16'h0, 2'b00, 0);
    // R2 other control symbols pass unchanged and advance
    cycle("R2",  0, 1, 16'hF7FB, 2'b11, 0, 1, 16'hFD3C, 2'b11, 0);
    cycle("R2",  0, 1, 16'hF733, 2'b10, 0, 0, 16'h0, 2'b00, 0);
    // R7 bypass keeps data clear, LFSR still steps
    cycle("R7",  1, 1, 16'hC3C3, 2'b00, 0, 1, 16'h3C3C, 2'b00, 0);
    cycle("R7",  0, 1, 16'h0000, 2'b00, 0, 1, 16'h0000, 2'b00, 0);
    // R8 compliance keeps data clear and freezes LFSR; comma still reloads
    cycle("R8",  0, 1, 16'h4A4A, 2'b00, 1, 0, 16'h0, 2'b00, 0);
    cycle("R8",  0, 1, 16'hBC4A, 2'b10, 1, 0, 16'h0, 2'b00, 0);
    cycle("R8",  0, 1, 16'h0000, 2'b00, 0, 0, 16'h0, 2'b00, 0);
    // R11 invalid cycles hold outputs and LFSR; R1 valid follows
    cycle("R11", 0, 0, 16'hFFFF, 2'b11, 0, 0, 16'hFFFF, 2'b11, 0);
    cycle("R11", 0, 0, 16'h0000, 2'b00, 0, 0, 16'h0, 2'b00, 0);
    cycle("R1",  0, 1, 16'h0000, 2'b00, 0, 1, 16'h0000, 2'b00, 0);

    // Random mix, both paths, checked against the model (R3 R5 R6 R7 R8 R11)
    for (int n = 0; n < 600; n++) begin
      logic byp;
      rand_sym(s, kk); d0[7:0] = s; k0[0] = kk;
      rand_sym(s, kk); d0[15:8] = s; k0[1] = kk;
      rand_sym(s, kk); d1[7:0] = s; k1[0] = kk;
      rand_sym(s, kk); d1[15:8] = s; k1[1] = kk;
      byp = ((n / 100) % 3) == 2;
      cycle("R3", byp, ($urandom % 4) != 0, d0, k0, ($urandom % 10) == 0,
            ($urandom % 4) != 0, d1, k1, ($urandom % 10) == 0);
    end

    // R9 loop-back: scramble a stream, then descramble it
    for (int j = 0; j <= RT_N; j++) begin
      if (j < RT_N) begin
        if (j == 0) begin rt_d[j] = {8'h11, 8'hBC}; rt_k[j] = 2'b01; end
        else begin
          rand_sym(s, kk); rt_d[j][7:0] = s;  rt_k[j][0] = kk;
          rand_sym(s, kk); rt_d[j][15:8] = s; rt_k[j][1] = kk;
        end
        cycle("R9", 0, 1, rt_d[j], rt_k[j], 0, 0, 16'h0, 2'b00, 0);
      end else begin
        cycle("R9", 0, 0, 16'h0, 2'b00, 0, 0, 16'h0, 2'b00, 0);
      end
      if (j > 0) begin rt_sd[j-1] = tx_out_data; rt_sk[j-1] = tx_out_k; end
    end
    for (int j = 0; j <= RT_N; j++) begin
      if (j < RT_N) cycle("R9", 0, 0, 16'h0, 2'b00, 0, 1, rt_sd[j], rt_sk[j], 0);
      else          cycle("R9", 0, 0, 16'h0, 2'b00, 0, 0, 16'h0, 2'b00, 0);
      if (j > 0) begin
        chk("R9", "loopback_data", rx_out_data, rt_d[j-1]);
        chk("R9", "loopback_k", {14'd0, rx_out_k}, {14'd0, rt_k[j-1]});
      end
    end
    cycle("R1", 0, 0, 16'h0, 2'b00, 0, 0, 16'h0, 2'b00, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule